// File: doc/BRIEF.md
# Variable-Length Instruction Boundary Decoder

This block walks a stream of instruction bytes, taking one byte per cycle through a valid/ready handshake. It finds where each instruction starts and ends. The first byte of every instruction carries a 6-bit function code plus a direction flag and a width flag. A parameterised lookup on the function code decides whether the instruction ends there or carries an addressing byte. The addressing byte holds a mode field, a register field and a register/memory field. Together the mode and register/memory fields set how many displacement bytes follow, from zero to two.

Displacement bytes arrive least significant first. A one-byte displacement is extended to 16 bits. On the cycle the final byte of an instruction is accepted, the block raises a one-cycle completion pulse. In that same cycle it presents a record with the decoded fields, the assembled displacement and the byte length. The next accepted byte is always taken as a new opcode. A pipeline front end places the block directly on its byte fetch path to mark instruction boundaries.

Top module: `vl_insn_splitter`

## Requirements
- R1: In a completed record, the function code is bits 7:2 of the opcode byte, the direction flag is bit 1 (1 = register field names the destination) and the width flag is bit 0 (1 = 16-bit word, 0 = byte).
- R2: An opcode whose function code has its bit set in SHORT_OPS completes in one byte. It gives length 1, with mode, register, register/memory and displacement all reported as zero.
- R3: The addressing byte is split as mode in bits 7:6, register in bits 5:3 and register/memory in bits 2:0, and these values appear in the record.
- R4: Mode 11 (register to register) completes with the addressing byte: length 2, displacement 0.
- R5: Mode 00 with a register/memory value other than 110 completes with the addressing byte: length 2, displacement 0.
- R6: Mode 00 with register/memory 110 takes two more bytes as a direct 16-bit address, low byte first: length 4.
- R7: Mode 01 takes one displacement byte, sign-extended to 16 bits (with SEXT_SHORT=1): length 3.
- R8: Mode 10 takes two displacement bytes, the first being the low byte: length 4.
- R9: `done` is high exactly in the cycle the final byte of an instruction is accepted, and the next accepted byte is decoded as an opcode.
- R10: Cycles with `in_valid` low accept nothing. The byte value on such cycles has no effect on the decoding in progress.
- R11: A synchronous `rst` discards any partly received instruction so that the next accepted byte is an opcode. `in_ready` is always high, and after reset `done` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A byte is offered |
| in_byte | input | 8 | Offered instruction byte |
| in_ready | output | 1 | Block takes a byte this cycle |
| done | output | 1 | Final byte of an instruction accepted this cycle |
| rec_func | output | 6 | Function code |
| rec_dir | output | 1 | Direction flag |
| rec_wide | output | 1 | Width flag |
| rec_mode | output | 2 | Addressing mode field |
| rec_reg | output | 3 | Register field |
| rec_rm | output | 3 | Register/memory field |
| rec_disp | output | 16 | Assembled displacement |
| rec_len | output | 3 | Instruction length in bytes |

## Verification
The bench builds the block with SHORT_OPS marking function codes 0, 4 and 63 as single-byte, SEXT_SHORT=1 and DIRECT_RM=110. This mix of single-byte and addressed opcodes in one stream brings every mode, the direct-address exception and both signs of a one-byte displacement within reach. Vectors are replayed both back to back and with idle gaps that carry junk bytes. A reset in the middle of an instruction is then shown to turn what would have been an addressing byte back into an opcode.

// File: rtl/vlsplit_pkg.sv
package vlsplit_pkg;
   localparam int OPC_W  = 6;
   localparam int BYTE_W = 8;
   localparam int DISP_W = 2 * BYTE_W;
   localparam int LEN_W  = 3;

   typedef enum logic [1:0] {PH_OPC, PH_ADR, PH_DSP} phase_e;

   typedef struct packed {
      logic [1:0] mode;
      logic [2:0] regf;
      logic [2:0] rm;
   } adr_t;

   localparam logic [1:0] MD_NODISP = 2'b00;
   localparam logic [1:0] MD_D8     = 2'b01;
   localparam logic [1:0] MD_D16    = 2'b10;
   localparam logic [1:0] MD_REG    = 2'b11;
endpackage

// File: rtl/vlsplit_opc_class.sv
module vlsplit_opc_class
   import vlsplit_pkg::*;
#(
   parameter logic [(1<<OPC_W)-1:0] SHORT_OPS = 64'hF000_0000_0000_0001
) (
   input  logic [OPC_W-1:0] func,
   output logic             single
);
   generate
      if (SHORT_OPS == '0) begin : g_none
         assign single = 1'b0;
      end else begin : g_table
         assign single = SHORT_OPS[func];
      end
   endgenerate
endmodule

// File: rtl/vlsplit_disp_count.sv
module vlsplit_disp_count
   import vlsplit_pkg::*;
#(
   parameter logic [2:0] DIRECT_RM = 3'b110
) (
   input  adr_t       adr,
   output logic [1:0] nbytes
);
   always_comb begin
      unique case (adr.mode)
         MD_REG:    nbytes = 2'd0;
         MD_D8:     nbytes = 2'd1;
         MD_D16:    nbytes = 2'd2;
         default:   nbytes = (adr.rm == DIRECT_RM) ? 2'd2 : 2'd0;
      endcase
   end
endmodule

// File: rtl/vlsplit_disp_acc.sv
module vlsplit_disp_acc
   import vlsplit_pkg::*;
#(
   parameter bit SEXT_SHORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              take_lo,
   input  logic [BYTE_W-1:0] byte_in,
   input  logic [1:0]        nbytes,
   output logic [DISP_W-1:0] disp
);
   logic [BYTE_W-1:0] lo_q;
   logic [DISP_W-1:0] short_ext;

   always_ff @(posedge clk) begin
      if (rst)          lo_q <= '0;
      else if (take_lo) lo_q <= byte_in;
   end

   generate
      if (SEXT_SHORT) begin : g_sext
         assign short_ext = {{BYTE_W{byte_in[BYTE_W-1]}}, byte_in};
      end else begin : g_zext
         assign short_ext = {{BYTE_W{1'b0}}, byte_in};
      end
   endgenerate

   always_comb begin
      unique case (nbytes)
         2'd1:    disp = short_ext;
         2'd2:    disp = {byte_in, lo_q};
         default: disp = '0;
      endcase
   end

   // R8: the held low byte only moves when a non-final displacement byte is taken
   a_r8_lo_hold: assert property (@(posedge clk) disable iff (rst)
      !take_lo |=> $stable(lo_q));
endmodule

// File: rtl/vl_insn_splitter.sv
module vl_insn_splitter
   import vlsplit_pkg::*;
#(
   parameter logic [(1<<OPC_W)-1:0] SHORT_OPS  = 64'hF000_0000_0000_0001,
   parameter bit                    SEXT_SHORT = 1'b1,
   parameter logic [2:0]            DIRECT_RM  = 3'b110
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_byte,
   output logic              in_ready,
   output logic              done,
   output logic [OPC_W-1:0]  rec_func,
   output logic              rec_dir,
   output logic              rec_wide,
   output logic [1:0]        rec_mode,
   output logic [2:0]        rec_reg,
   output logic [2:0]        rec_rm,
   output logic [DISP_W-1:0] rec_disp,
   output logic [LEN_W-1:0]  rec_len
);
   generate
      if (OPC_W + 2 != BYTE_W) begin : g_bad_width
         $error("opcode byte must hold the function code plus two flag bits");
      end
   endgenerate

   phase_e            st_q;
   logic [BYTE_W-1:0] op_q;
   adr_t              adr_q;
   logic [1:0]        need_q, got_q;

   logic              acc, single, last, take_lo;
   adr_t              adr_now, adr_sel;
   logic [1:0]        cnt_now;
   logic [BYTE_W-1:0] op_sel;
   logic [DISP_W-1:0] disp_dsp;

   assign in_ready = 1'b1;
   assign acc      = in_valid && in_ready;
   assign adr_now  = adr_t'(in_byte);

   vlsplit_opc_class #(.SHORT_OPS(SHORT_OPS)) u_class (
      .func   (in_byte[BYTE_W-1 -: OPC_W]),
      .single (single)
   );

   vlsplit_disp_count #(.DIRECT_RM(DIRECT_RM)) u_count (
      .adr    (adr_now),
      .nbytes (cnt_now)
   );

   vlsplit_disp_acc #(.SEXT_SHORT(SEXT_SHORT)) u_acc (
      .clk     (clk),
      .rst     (rst),
      .take_lo (take_lo),
      .byte_in (in_byte),
      .nbytes  (need_q),
      .disp    (disp_dsp)
   );

   always_comb begin
      op_sel   = op_q;
      adr_sel  = adr_q;
      last     = 1'b0;
      rec_len  = '0;
      rec_disp = '0;
      unique case (st_q)
         PH_OPC: begin
            op_sel  = in_byte;
            adr_sel = '0;
            last    = single;
            rec_len = LEN_W'(1);
         end
         PH_ADR: begin
            adr_sel = adr_now;
            last    = (cnt_now == 2'd0);
            rec_len = LEN_W'(2);
         end
         default: begin
            last     = (2'(got_q + 2'd1) == need_q);
            rec_len  = LEN_W'(2) + LEN_W'(need_q);
            rec_disp = disp_dsp;
         end
      endcase
   end

   assign done     = acc && last;
   assign take_lo  = acc && (st_q == PH_DSP) && !last;
   assign rec_func = op_sel[BYTE_W-1 -: OPC_W];
   assign rec_dir  = op_sel[1];
   assign rec_wide = op_sel[0];
   assign rec_mode = adr_sel.mode;
   assign rec_reg  = adr_sel.regf;
   assign rec_rm   = adr_sel.rm;

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= PH_OPC;
         op_q   <= '0;
         adr_q  <= '0;
         need_q <= '0;
         got_q  <= '0;
      end else if (acc) begin
         unique case (st_q)
            PH_OPC: begin
               op_q <= in_byte;
               if (!single) st_q <= PH_ADR;
            end
            PH_ADR: begin
               adr_q  <= adr_now;
               need_q <= cnt_now;
               got_q  <= '0;
               if (cnt_now != 2'd0) st_q <= PH_DSP;
               else                 st_q <= PH_OPC;
            end
            default: begin
               if (last) st_q  <= PH_OPC;
               else      got_q <= 2'(got_q + 2'd1);
            end
         endcase
      end
   end

   // R9: after a completed instruction the parser waits for an opcode
   a_r9_done_returns: assert property (@(posedge clk) disable iff (rst)
      done |=> (st_q == PH_OPC));

   // R11: a reset cycle leaves the parser in opcode wait
   a_r11_reset_phase: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (st_q == PH_OPC));

   // R6: displacement counting never runs past the amount announced
   a_r6_dsp_bound: assert property (@(posedge clk) disable iff (rst)
      (st_q == PH_DSP) |-> (got_q < need_q));

   // R2: an opcode outside the single-byte set moves on to the addressing byte
   a_r2_long_opc: assert property (@(posedge clk) disable iff (rst)
      (acc && st_q == PH_OPC && !SHORT_OPS[in_byte[BYTE_W-1 -: OPC_W]]) |=> (st_q == PH_ADR));

   // R10: idle cycles leave the parse position untouched
   a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(st_q) && $stable(got_q)));
endmodule

// File: tb/vl_insn_splitter_bench.sv
module vl_insn_splitter_bench;
   localparam int CLK_P = 10;
   localparam logic [63:0] B_SHORT = 64'h8000_0000_0000_0011;
   localparam int NVEC = 10;
   // entry: b0 b1 b2 b3 (32) | length (3) | displacement (16)
   localparam logic [50:0] VEC [NVEC] = '{
      {8'h03, 8'h00, 8'h00, 8'h00, 3'd1, 16'h0000},
      {8'h89, 8'hC3, 8'h00, 8'h00, 3'd2, 16'h0000},
      {8'h8B, 8'h05, 8'h00, 8'h00, 3'd2, 16'h0000},
      {8'h8A, 8'h06, 8'h34, 8'h12, 3'd4, 16'h1234},
      {8'h88, 8'h47, 8'h80, 8'h00, 3'd3, 16'hFF80},
      {8'h8C, 8'h45, 8'h7F, 8'h00, 3'd3, 16'h007F},
      {8'h24, 8'h9E, 8'hCD, 8'hAB, 3'd4, 16'hABCD},
      {8'hFE, 8'h00, 8'h00, 8'h00, 3'd1, 16'h0000},
      {8'h13, 8'h00, 8'h00, 8'h00, 3'd1, 16'h0000},
      {8'h30, 8'h36, 8'h00, 8'h80, 3'd4, 16'h8000}
   };

   logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
   logic [7:0] in_byte = 8'h00;
   logic in_ready, done, rec_dir, rec_wide;
   logic [5:0] rec_func;
   logic [1:0] rec_mode;
   logic [2:0] rec_reg, rec_rm, rec_len;
   logic [15:0] rec_disp;
   int checks = 0, errors = 0;
   bit finished = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   vl_insn_splitter #(.SHORT_OPS(B_SHORT), .SEXT_SHORT(1'b1), .DIRECT_RM(3'b110)) u_vl_insn_splitter (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
      .done(done), .rec_func(rec_func), .rec_dir(rec_dir), .rec_wide(rec_wide),
      .rec_mode(rec_mode), .rec_reg(rec_reg), .rec_rm(rec_rm), .rec_disp(rec_disp),
      .rec_len(rec_len)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // drive one byte at the falling edge; evaluate before the rising edge
   task automatic put(input logic [7:0] b, input bit is_last, input logic [50:0] v);
      logic [7:0] b0, b1;
      logic [1:0] md;
      string tag;
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = b;
      #1;
      check("R9 done timing", 32'(done), 32'(is_last));
      if (is_last) begin
         b0 = v[50:43];
         b1 = v[42:35];
         check("R1 func", 32'(rec_func), 32'(b0[7:2]));
         check("R1 flags", {rec_dir, rec_wide}, 32'(b0[1:0]));
         if (v[18:16] == 3'd1) begin
            check("R2 fields", {rec_mode, rec_reg, rec_rm}, 32'h0);
            tag = "R2";
         end else begin
            check("R3 fields", {rec_mode, rec_reg, rec_rm}, 32'(b1));
            md = b1[7:6];
            if (md == 2'b11)      tag = "R4";
            else if (md == 2'b01) tag = "R7";
            else if (md == 2'b10) tag = "R8";
            else if (b1[2:0] == 3'b110) tag = "R6";
            else                  tag = "R5";
         end
         check({tag, " length"}, 32'(rec_len), 32'(v[18:16]));
         check({tag, " displacement"}, 32'(rec_disp), 32'(v[15:0]));
      end
   endtask

   task automatic idle(input logic [7:0] junk);
      @(negedge clk);
      in_valid = 1'b0;
      in_byte  = junk;
      #1;
      check("R10 idle no done", 32'(done), 32'h0);
   endtask

   task automatic run_vec(input logic [50:0] v, input bit gaps);
      int n;
      n = int'(v[18:16]);
      for (int k = 0; k < n; k++) begin
         put(v[50 - 8*k -: 8], (k == n - 1), v);
         if (gaps && k != n - 1) idle(8'hC3 ^ 8'(k));
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check("R11 reset done low", 32'(done), 32'h0);
      check("R11 ready high", 32'(in_ready), 32'h1);
      @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < 2 * NVEC; i++) run_vec(VEC[i % NVEC], i >= NVEC);
      // R11: reset after an opcode drops it; 0x13 is then a one-byte opcode
      put(8'h89, 1'b0, VEC[1]);
      @(negedge clk);
      in_valid = 1'b0;
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      put(8'h13, 1'b1, VEC[8]);
      check("R11 resumes at opcode", 32'(rec_func), 32'h4);
      // R9: a full instruction, then the next byte is an opcode again
      run_vec(VEC[4], 1'b0);
      run_vec(VEC[0], 1'b1);
      @(negedge clk);
      in_valid = 1'b0;
      finished = 1'b1;
   end

   initial begin
      fork
         wait (finished);
         begin
            repeat (5000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule